// File: doc/BRIEF.md
# Block-Partitioned Two-Direction Recursive Low-Pass Filter

This block applies a zero-phase low-pass response to a continuous sample stream by means of a recursive (IIR) second-order section. The stream is cut into blocks of a fixed number of samples. Each block is first filtered causally. After the block's last sample, the filter keeps running on zero input until its impulse response has died away. The whole result is then run backwards in time through an identical section, again with a zero-input tail. The two passes together square the magnitude response and cancel the phase. The coefficients are therefore chosen so that a single pass meets the square root of the final ripple and attenuation figures.

A finished block result is longer than the block itself. It reaches back by the tail length and forward by the tail length. Neighbouring results therefore overlap by twice the tail length, and the block sums those overlapping samples into one continuous output. Input samples arrive on a valid/ready handshake into two alternating block buffers. This lets one block be collected while the previous one is filtered. One multiplier is time-shared by every tap of both passes. Latency is large, more than one block length, so the block suits paths without a feedback loop.

Top module: `fwdbwd_iir_filter`

## Requirements
- R1: During and right after synchronous reset, `in_ready` is 1 and `out_valid` is 0. The stored overlap tail starts at zero, so the first block's leading output samples see a zero predecessor.
- R2: A sample is taken only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` falls only when both block buffers hold unprocessed data, so no more than three blocks of input are ever accepted ahead of the emitted output. Data presented while `in_ready` is 0 has no effect on any output.
- R3: Each filter step is direct form I in two's complement. It computes acc = B0·x[n] + B1·x[n-1] + B2·x[n-2] − A1·y[n-1] − A2·y[n-2] at full precision. It then shifts acc arithmetically right by FRAC_W bits (rounding toward minus infinity) and saturates to a DATA_W-bit signed result y[n].
- R4: The forward pass starts from cleared history for every block. It runs BLK_LEN steps on the block's samples in arrival order, then TAIL_LEN steps with zero input, for BLK_LEN+TAIL_LEN forward results.
- R5: The backward pass starts from cleared history. It consumes the forward results from last to first, then TAIL_LEN zeros, for BLK_LEN+2·TAIL_LEN results. Backward result k belongs to position BLK_LEN+2·TAIL_LEN−1−k of the block's segment. Segment position p stands for time p−TAIL_LEN relative to the block's first sample.
- R6: For each block the output is segment positions 0..BLK_LEN−1 in increasing order. The first 2·TAIL_LEN of them each have the saved position BLK_LEN+j of the previous block's segment added in. Positions BLK_LEN..BLK_LEN+2·TAIL_LEN−1 are saved for the next block.
- R7: Exactly BLK_LEN output pulses are emitted per block, in increasing time order. `out_data` holds its value while `out_valid` is 0.
- R8: No output appears before the first BLK_LEN input samples have been accepted, and the count of emitted samples never reaches the count of accepted samples.
- R9: The overlap sum in R6 saturates to the DATA_W-bit signed range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block buffer space available |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One finished output sample this cycle |
| out_data | output | DATA_W | Signed output sample |

## Verification
- **Isolated impulse followed by a silent block.** This exposes the full two-direction impulse response, including the backward tail that lands in the previous time slot, so errors in reversal order, tail length or segment placement show up at distinct sample positions.
- **Constant and alternating-sign blocks.** These separate a correct overlap-add from a dropped or misaligned one: with a constant input the seam between blocks must be invisible, and the alternating pattern exercises every tap sign near the stopband.
- **Pseudo-random blocks fed with gaps, plus junk offered while not ready.** These confirm that only handshaked samples enter.
- **Full-scale runs.** These drive the section's saturation and the saturating overlap sum.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_GO,
    ST_WAIT,
    ST_EMIT
  } fbf_state_e;

  typedef enum logic {
    PASS_FWD,
    PASS_BWD
  } fbf_pass_e;
endpackage

// File: rtl/fbf_sdp_ram.sv
module fbf_sdp_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fbf_biquad_mac.sv
// One second-order section, direct form I, evaluated over five cycles
// through a single shared multiplier.
module fbf_biquad_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  parameter logic signed [COEF_W-1:0] CB0 = 16'sd1024,
  parameter logic signed [COEF_W-1:0] CB1 = 16'sd2048,
  parameter logic signed [COEF_W-1:0] CB2 = 16'sd1024,
  parameter logic signed [COEF_W-1:0] CA1 = -16'sd19661,
  parameter logic signed [COEF_W-1:0] CA2 = 16'sd7373
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hist_clr,
  input  logic                     go,
  input  logic signed [DATA_W-1:0] x_in,
  output logic                     done,
  output logic signed [DATA_W-1:0] y_out
);
  localparam int PW   = DATA_W + COEF_W;
  localparam int ACCW = PW + 3;
  localparam logic signed [ACCW-1:0] SAT_HI = {{(ACCW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SAT_LO = {{(ACCW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] x0, x1, x2, y1, y2;
  logic [2:0]               ph;
  logic                     busy;
  logic signed [ACCW-1:0]   acc;

  logic signed [COEF_W-1:0] cmux;
  logic signed [DATA_W-1:0] dmux;
  logic                     sub;
  logic signed [PW-1:0]     prod;
  logic signed [ACCW-1:0]   acc_nx, acc_sh;
  logic signed [DATA_W-1:0] y_sat;

  always_comb begin
    cmux = CB0; dmux = x0; sub = 1'b0;
    case (ph)
      3'd1:    begin cmux = CB1; dmux = x1; end
      3'd2:    begin cmux = CB2; dmux = x2; end
      3'd3:    begin cmux = CA1; dmux = y1; sub = 1'b1; end
      3'd4:    begin cmux = CA2; dmux = y2; sub = 1'b1; end
      default: begin cmux = CB0; dmux = x0; end
    endcase
  end

  assign prod   = cmux * dmux;
  assign acc_nx = sub ? acc - {{(ACCW-PW){prod[PW-1]}}, prod}
                      : acc + {{(ACCW-PW){prod[PW-1]}}, prod};
  assign acc_sh = acc_nx >>> FRAC_W;

  always_comb begin
    if (acc_sh > SAT_HI)      y_sat = SAT_HI[DATA_W-1:0];
    else if (acc_sh < SAT_LO) y_sat = SAT_LO[DATA_W-1:0];
    else                      y_sat = acc_sh[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x0 <= '0; x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
      ph <= '0; busy <= 1'b0; acc <= '0; done <= 1'b0; y_out <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        x0   <= x_in;
        acc  <= '0;
        ph   <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (ph == 3'd4) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          y_out <= y_sat;
          x2    <= x1;
          x1    <= x0;
          y2    <= y1;
          y1    <= y_sat;
        end else begin
          acc <= acc_nx;
          ph  <= ph + 3'd1;
        end
      end else if (hist_clr) begin
        x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
      end
    end
  end
endmodule

// File: rtl/fbf_overlap_add.sv
// Emits the leading part of a segment with the saved tail added, and
// stores the trailing part for the next block.
module fbf_overlap_add #(
  parameter int DATA_W   = 16,
  parameter int BLK_LEN  = 32,
  parameter int TAIL_LEN = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_vld,
  input  logic [$clog2(BLK_LEN+2*TAIL_LEN)-1:0] rd_idx,
  input  logic signed [DATA_W-1:0]   rd_data,
  output logic                       out_valid,
  output logic signed [DATA_W-1:0]   out_data
);
  localparam int SEG_LEN = BLK_LEN + 2*TAIL_LEN;
  localparam int SA      = $clog2(SEG_LEN);
  localparam int OVL_N   = 2*TAIL_LEN;
  localparam int OW      = $clog2(OVL_N);
  localparam logic [SA-1:0] BLK_S = SA'(BLK_LEN);
  localparam logic [SA-1:0] OVL_S = SA'(OVL_N);

  logic signed [DATA_W-1:0] ovl [OVL_N];
  logic [OW-1:0]            ovl_rd_idx, ovl_wr_idx;
  logic signed [DATA_W-1:0] addend;
  logic signed [DATA_W:0]   sum;
  logic signed [DATA_W-1:0] sum_sat;

  assign ovl_rd_idx = rd_idx[OW-1:0];
  assign ovl_wr_idx = OW'(rd_idx - BLK_S);
  assign addend     = (rd_idx < OVL_S) ? ovl[ovl_rd_idx] : '0;
  assign sum        = {addend[DATA_W-1], addend} + {rd_data[DATA_W-1], rd_data};

  always_comb begin
    if (sum[DATA_W] != sum[DATA_W-1])
      sum_sat = sum[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    else
      sum_sat = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < OVL_N; i++) ovl[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (rd_vld) begin
        if (rd_idx < BLK_S) begin
          out_valid <= 1'b1;
          out_data  <= sum_sat;
        end else begin
          ovl[ovl_wr_idx] <= rd_data;
        end
      end
    end
  end
endmodule

// File: rtl/fwdbwd_iir_filter.sv
module fwdbwd_iir_filter
  import fbf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int FRAC_W   = 14,
  parameter int BLK_LEN  = 32,
  parameter int TAIL_LEN = 12,
  parameter logic signed [COEF_W-1:0] CB0 = 16'sd1024,
  parameter logic signed [COEF_W-1:0] CB1 = 16'sd2048,
  parameter logic signed [COEF_W-1:0] CB2 = 16'sd1024,
  parameter logic signed [COEF_W-1:0] CA1 = -16'sd19661,
  parameter logic signed [COEF_W-1:0] CA2 = 16'sd7373
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int FWD_LEN = BLK_LEN + TAIL_LEN;
  localparam int SEG_LEN = BLK_LEN + 2*TAIL_LEN;
  localparam int SA      = $clog2(SEG_LEN);
  localparam int IA      = $clog2(BLK_LEN);
  localparam int BA      = IA + 1;
  localparam logic [SA-1:0] BLK_S  = SA'(BLK_LEN);
  localparam logic [SA-1:0] FWD_S  = SA'(FWD_LEN);
  localparam logic [SA-1:0] FWD_LS = SA'(FWD_LEN - 1);
  localparam logic [SA-1:0] SEG_LS = SA'(SEG_LEN - 1);
  localparam logic [IA-1:0] BLK_LI = IA'(BLK_LEN - 1);

  // input side: two alternating block buffers
  logic          wr_bank, rd_bank;
  logic [IA-1:0] wr_idx;
  logic [1:0]    full;
  logic          accept, fwd_free;

  assign in_ready = ~full[wr_bank];
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bank <= 1'b0;
      wr_idx  <= '0;
    end else if (accept) begin
      if (wr_idx == BLK_LI) begin
        wr_idx  <= '0;
        wr_bank <= ~wr_bank;
      end else begin
        wr_idx <= wr_idx + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_full
    always_ff @(posedge clk) begin
      if (rst) full[b] <= 1'b0;
      else if (accept && wr_bank == b[0] && wr_idx == BLK_LI) full[b] <= 1'b1;
      else if (fwd_free && rd_bank == b[0]) full[b] <= 1'b0;
    end
  end

  // processing sequencer
  fbf_state_e state;
  fbf_pass_e  pass;
  logic [SA-1:0] step;
  logic          mac_go, mac_done, hist_clr;
  logic signed [DATA_W-1:0] mac_x, mac_y;
  logic [DATA_W-1:0] bank_q, seg_q;
  logic [BA-1:0]     bank_raddr;
  logic [SA-1:0]     seg_raddr, seg_waddr;
  logic              seg_we;
  logic              emit_vld;
  logic [SA-1:0]     emit_idx;

  assign bank_raddr = {rd_bank, step[IA-1:0]};
  assign seg_raddr  = (state == ST_EMIT) ? step : (FWD_LS - step);
  assign seg_waddr  = (pass == PASS_FWD) ? step : (SEG_LS - step);
  assign seg_we     = (state == ST_WAIT) && mac_done;
  assign mac_go     = (state == ST_GO);
  assign mac_x      = (pass == PASS_FWD) ? ((step < BLK_S) ? $signed(bank_q) : '0)
                                         : ((step < FWD_S) ? $signed(seg_q)  : '0);
  assign fwd_free   = seg_we && pass == PASS_FWD && step == FWD_LS;
  assign hist_clr   = (state == ST_IDLE && full[rd_bank]) || fwd_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pass     <= PASS_FWD;
      step     <= '0;
      rd_bank  <= 1'b0;
      emit_vld <= 1'b0;
      emit_idx <= '0;
    end else begin
      emit_vld <= 1'b0;
      case (state)
        ST_IDLE: if (full[rd_bank]) begin
          pass  <= PASS_FWD;
          step  <= '0;
          state <= ST_RD;
        end
        ST_RD:   state <= ST_GO;
        ST_GO:   state <= ST_WAIT;
        ST_WAIT: if (mac_done) begin
          if (pass == PASS_FWD && step == FWD_LS) begin
            rd_bank <= ~rd_bank;
            pass    <= PASS_BWD;
            step    <= '0;
            state   <= ST_RD;
          end else if (pass == PASS_BWD && step == SEG_LS) begin
            step  <= '0;
            state <= ST_EMIT;
          end else begin
            step  <= step + 1'b1;
            state <= ST_RD;
          end
        end
        ST_EMIT: begin
          emit_vld <= 1'b1;
          emit_idx <= step;
          if (step == SEG_LS) state <= ST_IDLE;
          else                step  <= step + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  fbf_sdp_ram #(.DW(DATA_W), .DEPTH(1 << BA), .AW(BA)) u_bank_ram (
    .clk   (clk),
    .we    (accept),
    .waddr ({wr_bank, wr_idx}),
    .wdata (in_data),
    .raddr (bank_raddr),
    .rdata (bank_q)
  );

  fbf_sdp_ram #(.DW(DATA_W), .DEPTH(SEG_LEN), .AW(SA)) u_seg_ram (
    .clk   (clk),
    .we    (seg_we),
    .waddr (seg_waddr),
    .wdata (mac_y),
    .raddr (seg_raddr),
    .rdata (seg_q)
  );

  fbf_biquad_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .CB0(CB0), .CB1(CB1), .CB2(CB2), .CA1(CA1), .CA2(CA2)
  ) u_mac (
    .clk      (clk),
    .rst      (rst),
    .hist_clr (hist_clr),
    .go       (mac_go),
    .x_in     (mac_x),
    .done     (mac_done),
    .y_out    (mac_y)
  );

  logic signed [DATA_W-1:0] ola_data;

  fbf_overlap_add #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN), .TAIL_LEN(TAIL_LEN)) u_ola (
    .clk       (clk),
    .rst       (rst),
    .rd_vld    (emit_vld),
    .rd_idx    (emit_idx),
    .rd_data   ($signed(seg_q)),
    .out_valid (out_valid),
    .out_data  (ola_data)
  );

  assign out_data = ola_data;
endmodule

// File: rtl/fwdbwd_iir_filter_chk.sv
module fwdbwd_iir_filter_chk #(
  parameter int DATA_W  = 16,
  parameter int BLK_LEN = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  int n_in, n_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_in  <= 0;
      n_out <= 0;
    end else begin
      if (in_valid && in_ready) n_in <= n_in + 1;
      if (out_valid)            n_out <= n_out + 1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) $fell(rst) |-> (in_ready && !out_valid));

  // R8
  no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (n_in >= BLK_LEN && n_out < n_in));

  // R2
  buffer_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (n_in - n_out) <= 3*BLK_LEN);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

bind fwdbwd_iir_filter fwdbwd_iir_filter_chk #(.DATA_W(DATA_W), .BLK_LEN(BLK_LEN)) u_chk (.*);

// File: tb/fwdbwd_iir_filter_bench.sv
module fwdbwd_iir_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int FRAC  = 14;
  localparam int BLEN  = 32;
  localparam int TL    = 12;
  localparam int FWDN  = BLEN + TL;
  localparam int SEGN  = BLEN + 2*TL;
  localparam int K_B0  = 1024;
  localparam int K_B1  = 2048;
  localparam int K_B2  = 1024;
  localparam int K_A1  = -19661;
  localparam int K_A2  = 7373;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwdbwd_iir_filter #(
    .DATA_W(DW), .COEF_W(CW), .FRAC_W(FRAC), .BLK_LEN(BLEN), .TAIL_LEN(TL),
    .CB0(CW'(K_B0)), .CB1(CW'(K_B1)), .CB2(CW'(K_B2)), .CA1(CW'(K_A1)), .CA2(CW'(K_A2))
  ) u_fwdbwd_iir_filter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  int    n_acc = 0;
  bit    wd_hit = 1'b0;
  int    exp_q[$];
  string tag_q[$];
  int    ovl_m [2*TL];
  int    blk [BLEN];
  int    lfsr = 32'hACE1;

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // R3 R4 R5 R6 R9: expected result of one block, appended to the scoreboard
  task automatic model_block(input string tag);
    int f [FWDN];
    int sg [SEGN];
    int x1, x2, y1, y2, xv, yv;
    longint a;
    x1 = 0; x2 = 0; y1 = 0; y2 = 0;
    for (int n = 0; n < FWDN; n++) begin
      xv = (n < BLEN) ? blk[n] : 0;
      a  = longint'(K_B0)*xv + longint'(K_B1)*x1 + longint'(K_B2)*x2
         - longint'(K_A1)*y1 - longint'(K_A2)*y2;
      yv = sat16(a >>> FRAC);
      x2 = x1; x1 = xv; y2 = y1; y1 = yv;
      f[n] = yv;
    end
    x1 = 0; x2 = 0; y1 = 0; y2 = 0;
    for (int k = 0; k < SEGN; k++) begin
      xv = (k < FWDN) ? f[FWDN-1-k] : 0;
      a  = longint'(K_B0)*xv + longint'(K_B1)*x1 + longint'(K_B2)*x2
         - longint'(K_A1)*y1 - longint'(K_A2)*y2;
      yv = sat16(a >>> FRAC);
      x2 = x1; x1 = xv; y2 = y1; y1 = yv;
      sg[SEGN-1-k] = yv;
    end
    for (int p = 0; p < BLEN; p++) begin
      exp_q.push_back(sat16(longint'(sg[p]) + ((p < 2*TL) ? ovl_m[p] : 0)));
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 2*TL; i++) ovl_m[i] = sg[BLEN+i];
  endtask

  // R2: offers one sample; junk is shown while the block is not ready
  task automatic push_sample(input int v);
    bit sent;
    sent = 1'b0;
    while (!sent && !wd_hit) begin
      @(negedge clk);
      in_valid = 1'b1;
      if (in_ready) begin
        in_data = v[DW-1:0];
        sent    = 1'b1;
        n_acc++;
      end else begin
        in_data = 16'h5A3C;
      end
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'hC3A5;
    end
  endtask

  task automatic drive_block(input string tag, input int gap);
    model_block(tag);
    for (int i = 0; i < BLEN; i++) begin
      push_sample(blk[i]);
      if (gap > 0 && (i % 3) == 1) idle_cycles(gap);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      n_vec++;
      if (n_acc < BLEN) begin
        n_bad++;
        $display("FAIL R8: output with %0d accepted, expected at least %0d", n_acc, BLEN);
      end
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7: unexpected output %0d, expected none", $signed(out_data));
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ($signed(out_data) != e) begin
          n_bad++;
          $display("FAIL %s: got %0d expected %0d", t, $signed(out_data), e);
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    wd_hit = 1'b1;
  end

  initial begin
    for (int i = 0; i < 2*TL; i++) ovl_m[i] = 0;
    repeat (4) @(posedge clk);
    // R1: state during reset
    @(negedge clk);
    n_vec++;
    if (!(in_ready === 1'b1 && out_valid === 1'b0)) begin
      n_bad++;
      $display("FAIL R1: in_ready=%b out_valid=%b expected 1/0 in reset", in_ready, out_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    n_vec++;
    if (!(in_ready === 1'b1 && out_valid === 1'b0)) begin
      n_bad++;
      $display("FAIL R1: in_ready=%b out_valid=%b expected 1/0 after reset", in_ready, out_valid);
    end

    // R4 R5: impulse, then silence to reveal the tails
    for (int i = 0; i < BLEN; i++) blk[i] = (i == 5) ? 8000 : 0;
    drive_block("R4 R5 impulse", 0);
    for (int i = 0; i < BLEN; i++) blk[i] = 0;
    drive_block("R5 R6 impulse tail", 0);
    // R6: constant level across block seams
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < BLEN; i++) blk[i] = 4000;
      drive_block("R6 constant", 0);
    end
    // R3: alternating sign
    for (int i = 0; i < BLEN; i++) blk[i] = (i % 2 == 0) ? 6000 : -6000;
    drive_block("R3 alternating", 0);
    // R2: pseudo-random with gaps and junk while stalled
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < BLEN; i++) begin
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        blk[i] = (lfsr % 24001) - 12000;
      end
      drive_block("R2 gapped random", 2);
    end
    // R3 R9: full-scale runs
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < BLEN; i++) blk[i] = (i < BLEN/2) ? 32767 : -32768;
      drive_block("R3 R9 full scale", 0);
    end
    for (int i = 0; i < BLEN; i++) blk[i] = 0;
    drive_block("R6 R7 final seam", 0);
    idle_cycles(1);

    while (exp_q.size() != 0 && !wd_hit) @(negedge clk);
    idle_cycles(50);
    if (wd_hit) begin
      n_bad++;
      $display("FAIL R7: watchdog expired with %0d outputs pending, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule